// File: doc/BRIEF.md
# Sequencing ADC Capture Controller

This block runs an external parallel analog-to-digital converter that sits behind an analog channel multiplexer. A conversion begins on a start event. In request mode the event is a single request pulse. In cyclic mode it is a periodic timer tick. The block holds the converter's convert phase for a fixed number of cycles and then waits for completion. Completion comes either from the converter's ready pin or from an internal trigger, and a configuration bit chooses which. The block then reads the sample through a chip-select window and emits it on an outbound byte stream as two bytes.

An 8-bit channel counter drives the multiplexer address. Software loads it with a start channel, and it steps by one after every finished conversion, so successive conversions walk through the analog inputs. If a start event arrives while a conversion is still running, it is dropped and a sticky overrun flag records it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, adc_cs_n = 1, adc_rc_n = 1, out_valid = 0, mux_addr = 0x00 and overrun = 0.
- R2: With cfg_cyclic = 0 only start_req starts a conversion. With cfg_cyclic = 1 only timer_tick does, and start_req has no effect.
- R3: After the clock edge that samples a start event in idle, adc_cs_n and adc_rc_n are both low for exactly CONV_CYC cycles (default 2).
- R4: After the convert phase, adc_cs_n and adc_rc_n are both high until the selected completion source is seen high at a clock edge. cfg_done_sel = 0 selects adc_rdy and cfg_done_sel = 1 selects done_trig. The unselected source has no effect.
- R5: After completion, adc_cs_n is low and adc_rc_n is high for exactly READ_CYC cycles (default 2). adc_data is captured at the clock edge that ends this read window.
- R6: out_valid is then high for exactly two consecutive cycles. out_byte carries sample bits [15:8] in the first cycle and bits [7:0] in the second. Sample bits at or above SAMPLE_W read as zero.
- R7: A cfg_addr_load pulse copies cfg_start_addr into mux_addr. After each second output byte, mux_addr increases by one, and 0xFF wraps to 0x00.
- R8: A start event sampled while the controller is not idle sets overrun, which stays high until reset. The conversion in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cyclic | input | 1 | 1: timer tick starts conversions; 0: request pulse does |
| cfg_done_sel | input | 1 | 1: internal trigger marks completion; 0: converter ready pin does |
| cfg_addr_load | input | 1 | Load pulse for the channel counter |
| cfg_start_addr | input | ADDR_W (8) | Start channel loaded on cfg_addr_load |
| start_req | input | 1 | Single conversion request |
| timer_tick | input | 1 | Periodic start tick |
| done_trig | input | 1 | Internal completion trigger |
| adc_rdy | input | 1 | Converter ready pin |
| adc_data | input | SAMPLE_W (12) | Converter parallel data |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc_n | output | 1 | Read/convert control, low = convert |
| mux_addr | output | ADDR_W (8) | Analog multiplexer channel |
| out_valid | output | 1 | Outbound byte valid |
| out_byte | output | 8 | Outbound byte, high half first |
| overrun | output | 1 | Sticky dropped-start flag |

## Verification
Call E0 the edge that samples a start. Convert is visible for the two cycles after E0, and the wait phase begins after E0+2. If completion is sampled at edge Ed, the read window occupies the two cycles after Ed. The high byte appears after Ed+2, the low byte after Ed+3, and the idle state with the stepped mux_addr after Ed+4. The bench drives inputs and samples outputs on the falling edge. It advances exactly one falling edge per rising edge and checks each phase in the cycle this schedule predicts, which catches a phase that is one cycle too long or too short.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_CONV = 3'd1,
      S_WAIT = 3'd2,
      S_READ = 3'd3,
      S_SEND = 3'd4
   } seq_state_t;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned MAX_SAMPLE_W = 16;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned CONV_CYC = 2,
   parameter int unsigned READ_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_evt,
   input  logic       done_evt,
   output seq_state_t state,
   output logic       latch_en,
   output logic       addr_step,
   output logic       byte_sel,
   output logic       ovr
);
   localparam int unsigned LONGEST = (CONV_CYC > READ_CYC) ? CONV_CYC : READ_CYC;
   localparam int unsigned CNT_W   = (LONGEST > 2) ? $clog2(LONGEST) : 1;
   localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
   localparam logic [CNT_W-1:0] READ_LAST = CNT_W'(READ_CYC - 1);
   localparam logic [CNT_W-1:0] SEND_LAST = CNT_W'(1);

   generate
      if (CONV_CYC < 2) begin : g_conv_bad
         $error("CONV_CYC must be at least 2");
      end
      if (READ_CYC < 1) begin : g_read_bad
         $error("READ_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
         ovr   <= 1'b0;
      end else begin
         if (start_evt && (state != S_IDLE)) ovr <= 1'b1;
         unique case (state)
            S_IDLE: if (start_evt) begin
               state <= S_CONV;
               cnt   <= '0;
            end
            S_CONV: if (cnt == CONV_LAST) begin
               state <= S_WAIT;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            S_WAIT: if (done_evt) begin
               state <= S_READ;
               cnt   <= '0;
            end
            S_READ: if (cnt == READ_LAST) begin
               state <= S_SEND;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            S_SEND: if (cnt == SEND_LAST) begin
               state <= S_IDLE;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: begin
               state <= S_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign latch_en  = (state == S_READ) && (cnt == READ_LAST);
   assign addr_step = (state == S_SEND) && (cnt == SEND_LAST);
   assign byte_sel  = cnt[0];

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);
   // R8
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && state != S_IDLE) |=> ovr);
   // R4
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT && !done_evt) |=> state == S_WAIT);
endmodule

// File: rtl/adc_mux_addr.sv
module adc_mux_addr #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_addr_bad
         $error("ADDR_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (step) addr <= addr + 1'b1;
   end

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(addr));
   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step) |=> addr == ADDR_W'($past(addr) + 1'b1));
endmodule

// File: rtl/adc_sample_pack.sv
module adc_sample_pack
   import adc_seq_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                latch_en,
   input  logic [SAMPLE_W-1:0] din,
   input  logic                byte_sel,
   output logic [BYTE_W-1:0]   byte_out
);
   localparam int unsigned PAD_W = MAX_SAMPLE_W - SAMPLE_W;

   generate
      if (SAMPLE_W < 1 || SAMPLE_W > MAX_SAMPLE_W) begin : g_w_bad
         $error("SAMPLE_W must be 1..16");
      end
   endgenerate

   logic [SAMPLE_W-1:0]     smp_q;
   logic [MAX_SAMPLE_W-1:0] smp_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        smp_q <= '0;
      else if (latch_en) smp_q <= din;
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign smp_ext = smp_q;
      end else begin : g_pad
         assign smp_ext = {{PAD_W{1'b0}}, smp_q};
      end
   endgenerate

   assign byte_out = byte_sel ? smp_ext[BYTE_W-1:0] : smp_ext[MAX_SAMPLE_W-1:BYTE_W];

   // R5
   smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en |=> $stable(smp_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CONV_CYC = 2,
   parameter int unsigned READ_CYC = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cyclic,
   input  logic                cfg_done_sel,
   input  logic                cfg_addr_load,
   input  logic [ADDR_W-1:0]   cfg_start_addr,
   input  logic                start_req,
   input  logic                timer_tick,
   input  logic                done_trig,
   input  logic                adc_rdy,
   input  logic [SAMPLE_W-1:0] adc_data,
   output logic                adc_cs_n,
   output logic                adc_rc_n,
   output logic [ADDR_W-1:0]   mux_addr,
   output logic                out_valid,
   output logic [7:0]          out_byte,
   output logic                overrun
);
   seq_state_t state;
   logic start_evt, done_evt, latch_en, addr_step, byte_sel;

   assign start_evt = cfg_cyclic   ? timer_tick : start_req;
   assign done_evt  = cfg_done_sel ? done_trig  : adc_rdy;

   adc_seq_fsm #(.CONV_CYC(CONV_CYC), .READ_CYC(READ_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .done_evt(done_evt),
      .state(state), .latch_en(latch_en), .addr_step(addr_step),
      .byte_sel(byte_sel), .ovr(overrun)
   );

   adc_mux_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(cfg_addr_load), .load_val(cfg_start_addr),
      .step(addr_step), .addr(mux_addr)
   );

   adc_sample_pack #(.SAMPLE_W(SAMPLE_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .din(adc_data),
      .byte_sel(byte_sel), .byte_out(out_byte)
   );

   assign adc_cs_n  = !((state == S_CONV) || (state == S_READ));
   assign adc_rc_n  = (state != S_CONV);
   assign out_valid = (state == S_SEND);

   // R3
   conv_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rc_n |-> !adc_cs_n);
   // R3
   conv_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rc_n) |=> !adc_rc_n);
   // R6
   pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |=> out_valid);
   // R6
   pair_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |=> !out_valid);
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_cyclic = 0, cfg_done_sel = 0, cfg_addr_load = 0;
   logic [7:0] cfg_start_addr = 0;
   logic start_req = 0, timer_tick = 0, done_trig = 0, adc_rdy = 0;
   logic [11:0] adc_data = 0;
   logic adc_cs_n, adc_rc_n, out_valid, overrun;
   logic [7:0] mux_addr, out_byte;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   adc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_cyclic(cfg_cyclic), .cfg_done_sel(cfg_done_sel),
      .cfg_addr_load(cfg_addr_load), .cfg_start_addr(cfg_start_addr),
      .start_req(start_req), .timer_tick(timer_tick), .done_trig(done_trig),
      .adc_rdy(adc_rdy), .adc_data(adc_data), .adc_cs_n(adc_cs_n), .adc_rc_n(adc_rc_n),
      .mux_addr(mux_addr), .out_valid(out_valid), .out_byte(out_byte), .overrun(overrun)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic load_addr(input logic [7:0] a);
      cfg_start_addr = a; cfg_addr_load = 1;
      @(negedge clk); cfg_addr_load = 0;
      @(negedge clk);
      chk("R7", "loaded mux_addr", mux_addr, a);
   endtask

   // One full conversion; checks every phase at its due cycle.
   task automatic run_conv(input bit trig_mode, input bit via_tick, input logic [11:0] smp,
                           input logic [7:0] a0, input bit stray, input bit poke);
      if (via_tick) timer_tick = 1; else start_req = 1;
      @(negedge clk); timer_tick = 0; start_req = 0;
      chk("R3", "conv cycle1 cs_n", adc_cs_n, 0);
      chk("R3", "conv cycle1 rc_n", adc_rc_n, 0);
      if (poke) begin
         if (via_tick) timer_tick = 1; else start_req = 1;
      end
      @(negedge clk); timer_tick = 0; start_req = 0;
      chk("R3", "conv cycle2 rc_n", adc_rc_n, 0);
      @(negedge clk);
      chk("R3", "wait rc_n", adc_rc_n, 1);
      chk("R4", "wait cs_n", adc_cs_n, 1);
      chk("R7", "addr during conv", mux_addr, a0);
      if (stray) begin
         if (trig_mode) adc_rdy = 1; else done_trig = 1;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4", "unselected source ignored cs_n", adc_cs_n, 1);
         end
         adc_rdy = 0; done_trig = 0;
      end
      adc_data = smp;
      if (trig_mode) done_trig = 1; else adc_rdy = 1;
      @(negedge clk); adc_rdy = 0; done_trig = 0;
      chk("R5", "read1 cs_n", adc_cs_n, 0);
      chk("R5", "read1 rc_n", adc_rc_n, 1);
      @(negedge clk);
      chk("R5", "read2 cs_n", adc_cs_n, 0);
      @(negedge clk); adc_data = 12'h000;
      chk("R6", "hi valid", out_valid, 1);
      chk("R6", "hi byte", out_byte, {4'h0, smp[11:8]});
      @(negedge clk);
      chk("R6", "lo valid", out_valid, 1);
      chk("R5", "lo byte", out_byte, smp[7:0]);
      @(negedge clk);
      chk("R6", "valid drops", out_valid, 0);
      chk("R5", "idle cs_n", adc_cs_n, 1);
      chk("R7", "addr stepped", mux_addr, 8'(a0 + 8'd1));
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "cs_n", adc_cs_n, 1);
      chk("R1", "rc_n", adc_rc_n, 1);
      chk("R1", "out_valid", out_valid, 0);
      chk("R1", "mux_addr", mux_addr, 0);
      chk("R1", "overrun", overrun, 0);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic t_cyclic();
      cfg_cyclic = 1; cfg_done_sel = 0;
      start_req = 1;
      @(negedge clk); start_req = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2", "start_req ignored in cyclic", adc_cs_n, 1);
      end
      run_conv(0, 1, 12'hFFF, 8'h12, 0, 0);
      chk("R8", "no overrun yet", overrun, 0);
      cfg_cyclic = 0;
      timer_tick = 1;
      @(negedge clk); timer_tick = 0;
      @(negedge clk);
      chk("R2", "tick ignored in request mode", adc_cs_n, 1);
   endtask

   task automatic t_overrun();
      run_conv(0, 0, 12'h5A5, 8'h13, 0, 1);
      chk("R8", "overrun set", overrun, 1);
      run_conv(0, 0, 12'h3C7, 8'h14, 0, 0);
      chk("R8", "overrun sticky", overrun, 1);
   endtask

   initial begin
      t_reset();
      load_addr(8'h10);
      cfg_done_sel = 0;
      run_conv(0, 0, 12'hABC, 8'h10, 1, 0);
      cfg_done_sel = 1;
      run_conv(1, 0, 12'h123, 8'h11, 1, 0);
      t_cyclic();
      cfg_done_sel = 0;
      t_overrun();
      load_addr(8'hFF);
      run_conv(0, 0, 12'h081, 8'hFF, 0, 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule